// File: doc/BRIEF.md
# I2C Bus Event Monitor

This block listens to the clock and data wires of a two-wire serial bus and never drives them. It oversamples both wires with a fast system clock, finds the bus conditions and clock edges, and follows each transfer with a four-state tracker. The result is a stream of decoded events. Each event lasts one system-clock pulse and carries a 4-bit code and an 8-bit payload.

The events are plain start, repeated start, stop, acknowledge, not-acknowledge, address read, address write, data read and data write. The read/write direction is taken from bit 0 of the address byte. It is held and used to tag every data byte that follows. The `addr_shift` input selects the address format: either the 7-bit address, which is the byte shifted right by one, or the raw byte including the direction bit.

The event stream has a valid strobe and no ready. A passive monitor cannot stall the bus, so the consumer must take every event in the cycle it is flagged. Back-pressure is not supported, and events are never held.

Top module: `i2c_watch`

## Requirements
- R1: A fall of the data wire while the clock wire is high, seen while searching for a start, emits event code 0 with payload 0 and starts address collection.
- R2: A rise of the data wire while the clock wire is high, seen while collecting data, emits code 2 with payload 0 and returns to searching. The next start is then reported with code 0 again.
- R3: Bits are sampled on rising edges of the clock wire and packed MSB first. Exactly 8 rising edges complete a byte.
- R4: The rising edge after a byte is the acknowledge bit. A data level of 0 emits code 3 and a level of 1 emits code 4, both with payload 0. After it, the monitor always collects data.
- R5: The first byte after any start is the address. Bit 0 = 1 means read (code 5) and 0 means write (code 6). The direction is held, and the following data bytes are reported with code 7 (read) or code 8 (write), with the byte as payload.
- R6: With `addr_shift` = 1 the address payload is the byte shifted right by one, so 0xA2 gives 0x51. With `addr_shift` = 0 it is the raw byte.
- R7: A start accepted while collecting data, with no stop since the previous start, emits code 1 with payload 0.
- R8: While searching for a start, a stop condition and clock edges produce no event.
- R9: While collecting the address or the acknowledge bit, start and stop conditions produce no event. Only rising clock edges are acted on.
- R10: `evt_valid` is high for exactly one system clock per event. Codes 0 to 4 always carry payload 0, and no code above 8 is ever produced.
- R11: After reset the monitor is searching, its repeated-start flag and direction are clear, and both wires are taken as previously high. Wires held high produce no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock wire, observed only |
| sda_in | input | 1 | Bus data wire, observed only |
| addr_shift | input | 1 | 1: report 7-bit address; 0: raw address byte |
| evt_valid | output | 1 | One-cycle strobe marking a new event |
| evt_code | output | 4 | Event code 0..8 |
| evt_data | output | 8 | Byte payload, 0 for condition and acknowledge events |

## Verification
The assertions assume that the two wires change far more slowly than the system clock. In particular, after synchronisation no two qualifying edges land in adjacent system cycles, which is what makes each event strobe stand alone. The stimulus holds every wire level for ten system clocks. It changes the data wire only while the clock wire is low, except where it forms start and stop conditions on purpose. It also forms those conditions inside address collection and during the search, to show that they are ignored there.

// File: rtl/i2c_watch_pkg.sv
package i2c_watch_pkg;
  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] EV_START   = 4'd0;
  localparam logic [CODE_W-1:0] EV_RESTART = 4'd1;
  localparam logic [CODE_W-1:0] EV_STOP    = 4'd2;
  localparam logic [CODE_W-1:0] EV_ACK     = 4'd3;
  localparam logic [CODE_W-1:0] EV_NACK    = 4'd4;
  localparam logic [CODE_W-1:0] EV_ADR_RD  = 4'd5;
  localparam logic [CODE_W-1:0] EV_ADR_WR  = 4'd6;
  localparam logic [CODE_W-1:0] EV_DAT_RD  = 4'd7;
  localparam logic [CODE_W-1:0] EV_DAT_WR  = 4'd8;

  typedef enum logic [1:0] {
    ST_SEEK = 2'd0,
    ST_ADDR = 2'd1,
    ST_ACKB = 2'd2,
    ST_DATA = 2'd3
  } trk_state_e;
endpackage

// File: rtl/i2c_watch_sync.sv
module i2c_watch_sync #(
  parameter int          WIDTH   = 2,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_watch_cond.sv
module i2c_watch_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic clk_rise,
  output logic cond_start,
  output logic cond_stop
);
  logic scl_prev, sda_prev;

  // Lines are taken as previously high after reset (idle bus).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  assign clk_rise   = !scl_prev && scl_s;
  assign cond_start = sda_prev && !sda_s && scl_s;
  assign cond_stop  = !sda_prev && sda_s && scl_s;
endmodule

// File: rtl/i2c_watch_trk.sv
module i2c_watch_trk
  import i2c_watch_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_shift,
  input  logic              sda_s,
  input  logic              clk_rise,
  input  logic              cond_start,
  input  logic              cond_stop,
  output logic              evt_valid,
  output logic [CODE_W-1:0] evt_code,
  output logic [BYTE_W-1:0] evt_data
);
  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  trk_state_e        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              open_txn;
  logic              dir_rd;

  logic              take_start, take_stop, take_bit, take_ack, byte_done;
  logic [BYTE_W-1:0] new_byte;
  logic              fire;
  logic [CODE_W-1:0] code_n;
  logic [BYTE_W-1:0] data_n;

  // Data bits win over conditions while collecting data.
  always_comb begin
    take_bit   = clk_rise && (state == ST_ADDR || state == ST_DATA);
    take_ack   = clk_rise && (state == ST_ACKB);
    take_start = cond_start &&
                 (state == ST_SEEK || (state == ST_DATA && !clk_rise));
    take_stop  = cond_stop && state == ST_DATA && !clk_rise;
    byte_done  = take_bit && (bit_cnt == LAST_BIT);
    new_byte   = {shreg[BYTE_W-2:0], sda_s};
  end

  always_comb begin
    fire   = 1'b0;
    code_n = EV_START;
    data_n = '0;
    if (take_start) begin
      fire   = 1'b1;
      code_n = open_txn ? EV_RESTART : EV_START;
    end else if (take_stop) begin
      fire   = 1'b1;
      code_n = EV_STOP;
    end else if (take_ack) begin
      fire   = 1'b1;
      code_n = sda_s ? EV_NACK : EV_ACK;
    end else if (byte_done) begin
      fire = 1'b1;
      if (state == ST_ADDR) begin
        code_n = new_byte[0] ? EV_ADR_RD : EV_ADR_WR;
        data_n = addr_shift ? {1'b0, new_byte[BYTE_W-1:1]} : new_byte;
      end else begin
        code_n = dir_rd ? EV_DAT_RD : EV_DAT_WR;
        data_n = new_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_SEEK;
      bit_cnt  <= '0;
      shreg    <= '0;
      open_txn <= 1'b0;
      dir_rd   <= 1'b0;
    end else if (take_start) begin
      state    <= ST_ADDR;
      bit_cnt  <= '0;
      shreg    <= '0;
      open_txn <= 1'b1;
      dir_rd   <= 1'b0;
    end else if (take_stop) begin
      state    <= ST_SEEK;
      bit_cnt  <= '0;
      shreg    <= '0;
      open_txn <= 1'b0;
      dir_rd   <= 1'b0;
    end else if (take_ack) begin
      state <= ST_DATA;
    end else if (take_bit) begin
      if (byte_done) begin
        bit_cnt <= '0;
        shreg   <= '0;
        state   <= ST_ACKB;
        if (state == ST_ADDR) dir_rd <= new_byte[0];
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
        shreg   <= new_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_valid <= 1'b0;
      evt_code  <= '0;
      evt_data  <= '0;
    end else begin
      evt_valid <= fire;
      if (fire) begin
        evt_code <= code_n;
        evt_data <= data_n;
      end
    end
  end
endmodule

// File: rtl/i2c_watch.sv
module i2c_watch
  import i2c_watch_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              addr_shift,
  output logic              evt_valid,
  output logic [CODE_W-1:0] evt_code,
  output logic [BYTE_W-1:0] evt_data
);
  logic [1:0] lines_s;
  logic       clk_rise, cond_start, cond_stop;

  i2c_watch_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_in, sda_in}),
    .q     (lines_s)
  );

  i2c_watch_cond u_cond (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (lines_s[1]),
    .sda_s      (lines_s[0]),
    .clk_rise   (clk_rise),
    .cond_start (cond_start),
    .cond_stop  (cond_stop)
  );

  i2c_watch_trk #(.BYTE_W(BYTE_W)) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_shift (addr_shift),
    .sda_s      (lines_s[0]),
    .clk_rise   (clk_rise),
    .cond_start (cond_start),
    .cond_stop  (cond_stop),
    .evt_valid  (evt_valid),
    .evt_code   (evt_code),
    .evt_data   (evt_data)
  );
endmodule

// File: rtl/i2c_watch_chk.sv
module i2c_watch_chk
  import i2c_watch_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_valid,
  input logic [CODE_W-1:0] evt_code,
  input logic [BYTE_W-1:0] evt_data
);
  logic [CODE_W-1:0] last_code;
  logic              open_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_code <= EV_STOP;
      open_seen <= 1'b0;
    end else if (evt_valid) begin
      last_code <= evt_code;
      if (evt_code == EV_START || evt_code == EV_RESTART) open_seen <= 1'b1;
      else if (evt_code == EV_STOP)                       open_seen <= 1'b0;
    end
  end

  // R10
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !evt_valid);

  // R10
  ctrl_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_code <= EV_NACK) |-> evt_data == '0);

  // R10
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> evt_code <= EV_DAT_WR);

  // R4
  ack_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && (evt_code == EV_ACK || evt_code == EV_NACK))
      |-> last_code >= EV_ADR_RD);

  // R5
  addr_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && (evt_code == EV_ADR_RD || evt_code == EV_ADR_WR))
      |-> (last_code == EV_START || last_code == EV_RESTART));

  // R7
  restart_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_code == EV_RESTART) |-> open_seen);

  // R2
  plain_start_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_code == EV_START) |-> !open_seen);
endmodule

bind i2c_watch i2c_watch_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_valid (evt_valid),
  .evt_code  (evt_code),
  .evt_data  (evt_data)
);

// File: tb/i2c_watch_bench.sv
module i2c_watch_bench;
  localparam int HOLD = 10;
  localparam int NVEC = 11;
  localparam logic [1:0] OP_START = 2'd0, OP_STOP = 2'd1, OP_BYTE = 2'd2;

  // {op[22:21], byte[20:13], ack[12], code[11:8], payload[7:0]}
  localparam logic [22:0] VECS [NVEC] = '{
    {OP_START, 8'h00, 1'b0, 4'd0, 8'h00},
    {OP_BYTE,  8'hA2, 1'b0, 4'd6, 8'h51},
    {OP_BYTE,  8'h3C, 1'b0, 4'd8, 8'h3C},
    {OP_BYTE,  8'hFF, 1'b1, 4'd8, 8'hFF},
    {OP_START, 8'h00, 1'b0, 4'd1, 8'h00},
    {OP_BYTE,  8'hA3, 1'b0, 4'd5, 8'h51},
    {OP_BYTE,  8'h5A, 1'b1, 4'd7, 8'h5A},
    {OP_STOP,  8'h00, 1'b0, 4'd2, 8'h00},
    {OP_START, 8'h00, 1'b0, 4'd0, 8'h00},
    {OP_BYTE,  8'h00, 1'b0, 4'd6, 8'h00},
    {OP_STOP,  8'h00, 1'b0, 4'd2, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda = 1'b1;
  logic       addr_shift = 1'b1;
  logic       evt_valid;
  logic [3:0] evt_code;
  logic [7:0] evt_data;

  int checks = 0;
  int fails  = 0;
  int ev_n   = 0;
  int wide_n = 0;
  logic [3:0] ev_code [64];
  logic [7:0] ev_data [64];
  logic       prev_valid = 1'b0;

  always #4 clk = ~clk;

  i2c_watch u_i2c_watch (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl),
    .sda_in     (sda),
    .addr_shift (addr_shift),
    .evt_valid  (evt_valid),
    .evt_code   (evt_code),
    .evt_data   (evt_data)
  );

  always @(negedge clk) begin
    if (evt_valid && ev_n < 64) begin
      ev_code[ev_n] = evt_code;
      ev_data[ev_n] = evt_data;
      ev_n++;
    end
    if (evt_valid && prev_valid) wide_n++;
    prev_valid = evt_valid;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_ev(input string req, input int idx, input int code, input int data);
    if (idx >= ev_n) begin
      checks++; fails++;
      $display("FAIL %s: actual no event %0d expected code %0d", req, idx, code);
    end else begin
      chk({req, " code"}, ev_code[idx], code);
      chk({req, " data"}, ev_data[idx], data);
    end
  endtask

  task automatic wt();
    repeat (HOLD) @(posedge clk);
  endtask

  task automatic bus_start();
    sda = 1'b1; wt(); scl = 1'b1; wt(); sda = 1'b0; wt(); scl = 1'b0; wt();
  endtask

  task automatic bus_stop();
    sda = 1'b0; wt(); scl = 1'b1; wt(); sda = 1'b1; wt();
  endtask

  task automatic bus_bit(input logic b);
    sda = b; wt(); scl = 1'b1; wt(); scl = 1'b0; wt();
  endtask

  task automatic bus_byte(input logic [7:0] v, input logic ack);
    for (int i = 7; i >= 0; i--) bus_bit(v[i]);
    bus_bit(ack);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int base;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (20) @(posedge clk);
    @(negedge clk);
    // R11: idle-high wires produce nothing after reset
    chk("R11 valid", evt_valid, 0);
    chk("R11 events", ev_n, 0);

    // R8: stop-like condition and clock edges while searching
    scl = 1'b0; wt(); sda = 1'b0; wt(); scl = 1'b1; wt(); sda = 1'b1; wt();
    chk("R8 events", ev_n, 0);

    // Table walk: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] op;
      op = VECS[i][22:21];
      base = ev_n;
      case (op)
        OP_START: bus_start();
        OP_STOP:  bus_stop();
        default:  bus_byte(VECS[i][20:13], VECS[i][12]);
      endcase
      wt();
      chk("R3 count", ev_n - base, (op == OP_BYTE) ? 2 : 1);
      chk_ev("R5/R7 vec", base, VECS[i][11:8], VECS[i][7:0]);
      if (op == OP_BYTE)
        chk_ev("R4 vec", base + 1, VECS[i][12] ? 4 : 3, 0);
    end

    // R9: start/stop conditions inside address collection are ignored
    base = ev_n;
    bus_start();
    sda = 1'b1; wt(); scl = 1'b1; wt(); sda = 1'b0; wt(); sda = 1'b1; wt();
    scl = 1'b0; wt();
    for (int i = 6; i >= 0; i--) bus_bit(8'hB4 >> i);
    bus_bit(1'b0);
    bus_stop(); wt();
    chk("R9 count", ev_n - base, 4);
    chk_ev("R9 start", base, 0, 0);
    chk_ev("R9 addr", base + 1, 6, 8'h5A);
    chk_ev("R9 ack", base + 2, 3, 0);
    chk_ev("R9 stop", base + 3, 2, 0);

    // R6: raw address format, read direction held for data
    addr_shift = 1'b0;
    base = ev_n;
    bus_start();
    bus_byte(8'hA3, 1'b0);
    bus_byte(8'h11, 1'b0);
    bus_stop(); wt();
    chk("R6 count", ev_n - base, 6);
    chk_ev("R1 start", base, 0, 0);
    chk_ev("R6 raw addr", base + 1, 5, 8'hA3);
    chk_ev("R5 read data", base + 3, 7, 8'h11);
    chk_ev("R2 stop", base + 5, 2, 0);

    // R10: every strobe was a single cycle
    chk("R10 pulse", wide_n, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule